// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block translates a virtual address into a physical address by searching a hashed page table. The page-number part of the address is folded by a hash into a bucket index. A small register file holds one head pointer per bucket. The walker follows that bucket's linked list of nodes through an external synchronous memory. Each node carries a page number, a frame number and a link to the next node. The walk stops at the first node whose page number equals the request; the frame from that node and the unchanged offset form the physical address.

A search can end in three ways. It hits on a match. It faults when it reaches a null link, or when the bucket is empty. It also faults when it has visited the maximum number of nodes without a match, which keeps a corrupted or circular chain from hanging the walker. Software fills the node memory itself and writes bucket heads through the head-load port. Only one request is handled at a time.

Top module: `hpt_walker`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `resp_valid` is 0, `mem_rd_en` is 0, and every bucket head reads as null (0).
- R2: The bucket index is the low `HASH_W` bits of (upper half of the page number XOR lower half). With the defaults this is bits [3:0] of `vpn[15:8] ^ vpn[7:0]`, where the page number is `req_vaddr[27:12]`.
- R3: A node word read from memory is laid out as page number in bits [35:20], frame number in bits [19:8] and next-node link in bits [7:0].
- R4: On a hit, `resp_fault` is 0 and `resp_paddr` equals {frame, `req_vaddr[11:0]`}, taken from the first node in chain order whose page number matches.
- R5: Each node visited costs exactly one memory read, one cycle long, addressed by the head pointer and then by each followed link. Counting the accepting clock edge as edge 1, `resp_valid` is seen after edge 2+2k, where k is the number of nodes visited.
- R6: A link or head value of 0 ends a chain. An empty bucket faults with no memory read (k = 0). A chain that ends without a match faults after visiting all of its nodes.
- R7: After `MAX_CHAIN` (default 8) visits without a match, the walk faults even if the link is non-null. A match on visit `MAX_CHAIN` is still a hit.
- R8: A request is accepted only while `req_ready` is 1. A request presented during a walk is ignored: it does not alter the current result and starts no later lookup.
- R9: A head write takes effect at the clock edge on which `tbl_we` is sampled. A walk whose hash cycle coincides with that edge uses the old head, and later walks use the new one.
- R10: `resp_valid` is a one-cycle pulse, after which `req_ready` returns to 1. On a fault, `resp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write strobe for a bucket head |
| tbl_bucket | input | HASH_W | Bucket index being written |
| tbl_head | input | PTR_W | New head pointer for that bucket (0 = empty) |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_en | output | 1 | Node memory read enable |
| mem_addr | output | PTR_W | Node memory address |
| mem_rdata | input | VPN_W+FRAME_W+PTR_W | Node word, valid the cycle after the read |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Result is a page fault |
| resp_paddr | output | FRAME_W+OFF_W | Physical address on a hit, 0 on a fault |

## Verification
Two things can happen on the same clock edge: a bucket-head write, and the hash step reading that same head for a walk already in flight. The bench raises `tbl_we` in exactly the cycle in which the walker sits in its hash step. It then expects the result and memory-read addresses that the old chain gives, and repeats the lookup to see the new chain take effect. It also drives a second request while a walk is busy and judges that the first response is unchanged and that no extra response follows.

// File: rtl/hpt_walker_pkg.sv
package hpt_walker_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_HASH,
        WS_FETCH,
        WS_MATCH,
        WS_REPLY
    } walk_state_e;

    localparam int unsigned NULL_LINK = 0;

    function automatic int unsigned node_width(input int unsigned vpn_w,
                                               input int unsigned frame_w,
                                               input int unsigned ptr_w);
        return vpn_w + frame_w + ptr_w;
    endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int VPN_W  = 16,
    parameter int HASH_W = 4
) (
    input  logic [VPN_W-1:0]  vpn,
    output logic [HASH_W-1:0] bucket
);
    localparam int HALF = VPN_W / 2;

    logic [HALF-1:0] folded;

    assign folded = vpn[VPN_W-1 -: HALF] ^ vpn[HALF-1:0];
    assign bucket = folded[HASH_W-1:0];

endmodule

// File: rtl/hpt_head_table.sv
module hpt_head_table #(
    parameter int HASH_W = 4,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HASH_W-1:0] wr_idx,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [HASH_W-1:0] rd_idx,
    output logic [PTR_W-1:0]  rd_ptr
);
    localparam int NBUCKET = 1 << HASH_W;

    logic [PTR_W-1:0] heads [NBUCKET];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUCKET; i++) begin
                heads[i] <= '0;
            end
        end else if (wr_en) begin
            heads[wr_idx] <= wr_ptr;
        end
    end

    assign rd_ptr = heads[rd_idx];

    // R9
    head_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (heads[$past(wr_idx)] == $past(wr_ptr)));

endmodule

// File: rtl/hpt_node_cmp.sv
module hpt_node_cmp #(
    parameter int VPN_W   = 16,
    parameter int FRAME_W = 12,
    parameter int PTR_W   = 8
) (
    input  logic [VPN_W+FRAME_W+PTR_W-1:0] node_word,
    input  logic [VPN_W-1:0]               want_vpn,
    output logic                           hit,
    output logic [FRAME_W-1:0]             frame,
    output logic [PTR_W-1:0]               link,
    output logic                           link_null
);
    localparam int LINK_LO  = 0;
    localparam int FRAME_LO = PTR_W;
    localparam int VPN_LO   = PTR_W + FRAME_W;

    logic [VPN_W-1:0] node_vpn;

    assign node_vpn  = node_word[VPN_LO   +: VPN_W];
    assign frame     = node_word[FRAME_LO +: FRAME_W];
    assign link      = node_word[LINK_LO  +: PTR_W];
    assign hit       = (node_vpn == want_vpn);
    assign link_null = (link == PTR_W'(hpt_walker_pkg::NULL_LINK));

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_walker_pkg::*;
#(
    parameter int VPN_W     = 16,
    parameter int OFF_W     = 12,
    parameter int FRAME_W   = 12,
    parameter int PTR_W     = 8,
    parameter int HASH_W    = 4,
    parameter int MAX_CHAIN = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   tbl_we,
    input  logic [HASH_W-1:0]                      tbl_bucket,
    input  logic [PTR_W-1:0]                       tbl_head,
    input  logic                                   req_valid,
    input  logic [VPN_W+OFF_W-1:0]                 req_vaddr,
    output logic                                   req_ready,
    output logic                                   mem_rd_en,
    output logic [PTR_W-1:0]                       mem_addr,
    input  logic [node_width(VPN_W,FRAME_W,PTR_W)-1:0] mem_rdata,
    output logic                                   resp_valid,
    output logic                                   resp_fault,
    output logic [FRAME_W+OFF_W-1:0]               resp_paddr
);
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = FRAME_W + OFF_W;
    localparam int CNT_W = $clog2(MAX_CHAIN + 1);

    walk_state_e        state;
    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic [PTR_W-1:0]   cur_ptr;
    logic [CNT_W-1:0]   visits;
    logic               fault_q;
    logic [PA_W-1:0]    paddr_q;

    logic [HASH_W-1:0]  bucket;
    logic [PTR_W-1:0]   head_ptr;
    logic               node_hit;
    logic [FRAME_W-1:0] node_frame;
    logic [PTR_W-1:0]   node_link;
    logic               node_link_null;
    logic               limit_hit;

    hpt_hash #(.VPN_W(VPN_W), .HASH_W(HASH_W)) hash_i (
        .vpn    (vpn_q),
        .bucket (bucket)
    );

    hpt_head_table #(.HASH_W(HASH_W), .PTR_W(PTR_W)) heads_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_we),
        .wr_idx (tbl_bucket),
        .wr_ptr (tbl_head),
        .rd_idx (bucket),
        .rd_ptr (head_ptr)
    );

    hpt_node_cmp #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .PTR_W(PTR_W)) cmp_i (
        .node_word (mem_rdata),
        .want_vpn  (vpn_q),
        .hit       (node_hit),
        .frame     (node_frame),
        .link      (node_link),
        .link_null (node_link_null)
    );

    assign limit_hit = (visits == CNT_W'(MAX_CHAIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WS_IDLE;
            vpn_q   <= '0;
            off_q   <= '0;
            cur_ptr <= '0;
            visits  <= '0;
            fault_q <= 1'b0;
            paddr_q <= '0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        vpn_q <= req_vaddr[VA_W-1:OFF_W];
                        off_q <= req_vaddr[OFF_W-1:0];
                        state <= WS_HASH;
                    end
                end
                WS_HASH: begin
                    visits <= '0;
                    if (head_ptr == PTR_W'(NULL_LINK)) begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                        state   <= WS_REPLY;
                    end else begin
                        cur_ptr <= head_ptr;
                        state   <= WS_FETCH;
                    end
                end
                WS_FETCH: begin
                    visits <= visits + 1'b1;
                    state  <= WS_MATCH;
                end
                WS_MATCH: begin
                    if (node_hit) begin
                        fault_q <= 1'b0;
                        paddr_q <= {node_frame, off_q};
                        state   <= WS_REPLY;
                    end else if (node_link_null || limit_hit) begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                        state   <= WS_REPLY;
                    end else begin
                        cur_ptr <= node_link;
                        state   <= WS_FETCH;
                    end
                end
                WS_REPLY: begin
                    state <= WS_IDLE;
                end
                default: begin
                    state <= WS_IDLE;
                end
            endcase
        end
    end

    assign req_ready  = (state == WS_IDLE);
    assign mem_rd_en  = (state == WS_FETCH);
    assign mem_addr   = cur_ptr;
    assign resp_valid = (state == WS_REPLY);
    assign resp_fault = fault_q;
    assign resp_paddr = paddr_q;

    // Checker-side count of reads made since the last accepted request
    logic [CNT_W:0] chk_reads;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_reads <= '0;
        end else if (req_valid && req_ready) begin
            chk_reads <= '0;
        end else if (mem_rd_en) begin
            chk_reads <= chk_reads + 1'b1;
        end
    end

    // R5
    one_read_per_node_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R7
    read_bound_chk: assert property (@(posedge clk) disable iff (rst)
        chk_reads <= (CNT_W+1)'(MAX_CHAIN));

    // R6
    hit_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> (chk_reads != '0));

    // R8
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    reply_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

    // R10
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W   = 16;
    localparam int OFF_W   = 12;
    localparam int FRAME_W = 12;
    localparam int PTR_W   = 8;
    localparam int HASH_W  = 4;
    localparam int MAXC    = 8;
    localparam int NODE_W  = VPN_W + FRAME_W + PTR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tbl_we = 1'b0;
    logic [HASH_W-1:0] tbl_bucket = '0;
    logic [PTR_W-1:0] tbl_head = '0;
    logic req_valid = 1'b0;
    logic [VPN_W+OFF_W-1:0] req_vaddr = '0;
    logic req_ready;
    logic mem_rd_en;
    logic [PTR_W-1:0] mem_addr;
    logic [NODE_W-1:0] mem_rdata = '0;
    logic resp_valid;
    logic resp_fault;
    logic [FRAME_W+OFF_W-1:0] resp_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_bucket(tbl_bucket), .tbl_head(tbl_head),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    // Node memory: synchronous, single port, read data one cycle after the enable
    logic [NODE_W-1:0] mem [256];
    logic [PTR_W-1:0]  rd_log [256];
    int rd_total = 0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_log[rd_total % 256] = mem_addr;
            rd_total = rd_total + 1;
        end
    end

    logic [PTR_W-1:0] hmodel [16];
    logic [PTR_W-1:0] exp_addr [MAXC];
    logic [VPN_W-1:0] ins_vpn [40];
    logic [HASH_W-1:0] wr_b;
    logic [PTR_W-1:0]  wr_p;
    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [HASH_W-1:0] bench_hash(input logic [VPN_W-1:0] v);
        logic [7:0] f;
        f = v[15:8] ^ v[7:0];
        return f[3:0];
    endfunction

    task automatic model_walk(input logic [VPN_W-1:0] vpn, output int visits,
                              output bit hit, output logic [FRAME_W-1:0] frame);
        logic [PTR_W-1:0] p;
        p = hmodel[bench_hash(vpn)];
        visits = 0; hit = 0; frame = '0;
        while (p != 0 && visits < MAXC) begin
            exp_addr[visits] = p;
            visits++;
            if (mem[p][35:20] == vpn) begin
                hit = 1;
                frame = mem[p][19:8];
                break;
            end
            p = mem[p][7:0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tbl_we = 1'b0; req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) hmodel[i] = '0;
    endtask

    task automatic load_head(input logic [HASH_W-1:0] b, input logic [PTR_W-1:0] p);
        @(negedge clk);
        tbl_we = 1'b1; tbl_bucket = b; tbl_head = p;
        @(negedge clk);
        tbl_we = 1'b0;
        hmodel[b] = p;
    endtask

    task automatic put_node(input int a, input logic [VPN_W-1:0] v,
                            input logic [FRAME_W-1:0] f, input logic [PTR_W-1:0] nx);
        mem[a] = {v, f, nx};
    endtask

    // mode 0: plain; 1: second request while busy; 2: head write during hash cycle
    task automatic do_lookup(input logic [VPN_W+OFF_W-1:0] va, input int mode,
                             input string req);
        int ev; bit eh; logic [FRAME_W-1:0] ef;
        logic [FRAME_W+OFF_W-1:0] exp_pa;
        int start, cyc, bad, extra;
        bit got;
        model_walk(va[27:12], ev, eh, ef);
        exp_pa = eh ? {ef, va[11:0]} : '0;
        start = rd_total;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        cyc = 0; got = 0;
        while (cyc < 60) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1) req_valid = 1'b0;
            if (mode == 1 && cyc == 3) begin
                req_valid = 1'b1; req_vaddr = va ^ 28'h5a5a000;
            end
            if (mode == 1 && cyc == 4) req_valid = 1'b0;
            if (mode == 2 && cyc == 1) begin
                tbl_we = 1'b1; tbl_bucket = wr_b; tbl_head = wr_p;
            end
            if (mode == 2 && cyc == 2) tbl_we = 1'b0;
            if (resp_valid) begin
                got = 1;
                break;
            end
        end
        req_valid = 1'b0;
        tbl_we = 1'b0;
        chk(got, req, "response seen", int'(got), 1);
        chk(cyc == 2 + 2*ev, req, "latency", cyc, 2 + 2*ev);
        chk(resp_fault == !eh, req, "fault flag", int'(resp_fault), int'(!eh));
        chk(resp_paddr == exp_pa, req, "physical address", int'(resp_paddr), int'(exp_pa));
        chk(rd_total - start == ev, req, "memory reads", rd_total - start, ev);
        bad = 0;
        for (int i = 0; i < ev; i++) begin
            if (rd_log[(start + i) % 256] != exp_addr[i]) bad++;
        end
        chk(bad == 0, req, "read address order", bad, 0);
        @(negedge clk);
        chk(!resp_valid && req_ready, "R10", "pulse ends",
            int'({resp_valid, req_ready}), 1);
        if (mode == 1) begin
            extra = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (resp_valid || !req_ready) extra++;
            end
            chk(extra == 0, "R8", "ignored request started no lookup", extra, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [VPN_W-1:0] v;
        logic [HASH_W-1:0] b;
        r = $urandom(32'd7);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 256; i++) rd_log[i] = '0;
        do_reset();

        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        chk(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", int'(mem_rd_en), 0);

        // R1/R6: all heads null after reset, empty bucket faults with no read
        do_lookup({16'h1234, 12'h0ab}, 0, "R6");

        // bucket 5: nine nodes, addresses 1..9
        for (int i = 1; i <= 9; i++) begin
            put_node(i, {8'(i), 8'(i) ^ 8'h05}, 12'(12'h100 + i),
                     (i < 9) ? 8'(i + 1) : 8'h00);
        end
        load_head(4'd5, 8'd1);
        // bucket 3: three nodes, null-terminated
        for (int j = 0; j < 3; j++) begin
            put_node(20 + j, {8'(8'h20 + j), 8'(8'h20 + j) ^ 8'h03},
                     12'(12'h300 + j), (j < 2) ? 8'(21 + j) : 8'h00);
        end
        load_head(4'd3, 8'd20);
        // bucket 7: circular pair
        put_node(30, {8'h70, 8'h77}, 12'h777, 8'd31);
        put_node(31, {8'h71, 8'h76}, 12'h776, 8'd30);
        load_head(4'd7, 8'd30);

        do_lookup({8'h01, 8'h04, 12'h3c5}, 0, "R2");   // bucket 5, first node
        do_lookup({8'h22, 8'h21, 12'hfff}, 0, "R3");   // bucket 3, third node
        do_lookup({8'h05, 8'h00, 12'h001}, 0, "R5");   // fifth node in chain
        do_lookup({8'h08, 8'h0d, 12'h800}, 0, "R7");   // match on visit 8
        do_lookup({8'h09, 8'h0c, 12'h010}, 0, "R7");   // ninth node beyond bound
        do_lookup({8'h72, 8'h75, 12'h020}, 0, "R7");   // circular chain, no match
        do_lookup({8'h2f, 8'h2c, 12'h030}, 0, "R6");   // chain ends at null
        do_lookup({8'h21, 8'h22, 12'h040}, 1, "R8");   // second request while busy

        // R9: head rewrite in the hash cycle; old chain still used
        wr_b = 4'd3; wr_p = 8'd21;
        do_lookup({8'h20, 8'h23, 12'h050}, 2, "R9");
        hmodel[3] = 8'd21;
        do_lookup({8'h20, 8'h23, 12'h060}, 0, "R9");  // node 20 now unreachable

        // Random phase on a freshly reset table
        do_reset();
        do_lookup({8'h20, 8'h23, 12'h070}, 0, "R1");  // heads cleared again
        for (int i = 0; i < 40; i++) begin
            r = $urandom;
            v = r[15:0];
            b = bench_hash(v);
            ins_vpn[i] = v;
            r = $urandom;
            put_node(64 + i, v, r[11:0], hmodel[b]);
            load_head(b, 8'(64 + i));
        end
        for (int i = 0; i < 60; i++) begin
            r = $urandom;
            if (i % 2 == 0) v = ins_vpn[r[31:16] % 40];
            else            v = r[31:16];
            do_lookup({v, r[11:0]}, 0, "R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule